// File: doc/BRIEF.md
# Multiplexed Burst Bus Master

This block is the master-side sequencer for a system bus where addresses and data travel over the same 64-bit path in separate phases, and where several masters share the bus through an external arbiter. A local requester presents an address, a size code, a direction and write data. The block checks that the request is legal. It then raises a bus request, waits for the grant and drives one address phase. After that it runs the data phases. Read data returns to the requester on each acknowledged beat. Write data is taken from the requester one beat at a time.

The size code alone picks the shape of the transfer. Sizes of one to eight bytes use a single data phase. The 32-byte size uses a fixed burst of four data phases and must start on a 32-byte boundary. The slave paces each beat with an acknowledge, and it can end the transfer early with an error. The requester always gets a one-cycle completion pulse that carries an error flag.

Top module: `burst_bus_master`

## Requirements
- R1: After reset, reqReady is 1 and busReq, adOe, addrPhase and rspValid are 0.
- R2: Size codes 0, 1, 2, 3 and 4 mean 1, 2, 4, 8 and 32 bytes. A request with code 5, 6 or 7 is rejected: in the following cycle rspValid and rspError are 1, and busReq is never raised.
- R3: A 32-byte request (code 4) whose address has any of bits [4:0] set is rejected in the same way as in R2, without requesting the bus.
- R4: busReq rises in the cycle after a legal request is accepted. No address phase occurs until busGrant has been high. The address phase is the cycle right after the first cycle in which busGrant is high.
- R5: The address phase lasts one cycle, with addrPhase=1 and adOe=1. adOut carries the address in bits [35:0], the size code in bits [62:60], the direction (1 = write) in bit 63, and zeros in all other bits.
- R6: Codes 0 to 3 complete after exactly one acknowledged data phase. Code 4 completes after exactly four.
- R7: A data beat completes only in a cycle where slvAck is 1. While slvAck and slvErr are both 0, no beat is delivered or consumed.
- R8: On a read, each acknowledged beat gives rdValid=1, and rdData equals the bus input adIn in that cycle, in beat order.
- R9: On a write, adOe is 1 and adOut equals reqWdata throughout every data phase. wrNext pulses in each acknowledged cycle so that the requester can present its next word.
- R10: slvErr in a data phase ends the transfer at once. In the next cycle rspValid and rspError are 1, and no further beat is taken.
- R11: busReq is 0 from the cycle after the final acknowledge or error onward. rspValid lasts one cycle, and reqReady returns in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Requester presents a transfer |
| reqAddr | input | 36 | Transfer byte address |
| reqSize | input | 3 | Size code (0..4 = 1,2,4,8,32 bytes) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | 64 | Current write word |
| reqReady | output | 1 | Block idle, can take a request |
| wrNext | output | 1 | Write beat consumed |
| rdValid | output | 1 | Read beat valid |
| rdData | output | 64 | Read beat data |
| rspValid | output | 1 | Transfer finished (one cycle) |
| rspError | output | 1 | Finished transfer failed or was rejected |
| busReq | output | 1 | Request to the arbiter |
| busGrant | input | 1 | Grant from the arbiter |
| addrPhase | output | 1 | Address phase marker |
| adOe | output | 1 | Output enable for the shared path |
| adOut | output | 64 | Value driven on the shared path |
| adIn | input | 64 | Value sampled from the shared path |
| slvAck | input | 1 | Slave completes the current beat |
| slvErr | input | 1 | Slave aborts the transfer |

## Verification
The assertions assume that the slave never raises slvAck and slvErr together, and that it responds only in the data phases of a transfer this master owns. They also assume that the arbiter holds busGrant only while busReq is high. The bench's slave model answers only after it has seen the address phase and only up to the number of beats the size code calls for. It stops after an error. Its grant model follows busReq and drops the grant as soon as the request falls.

// File: rtl/bbm_pkg.sv
package bbm_pkg;
  localparam int BUS_W = 64;
  localparam logic [2:0] SZ_1  = 3'd0;
  localparam logic [2:0] SZ_2  = 3'd1;
  localparam logic [2:0] SZ_4  = 3'd2;
  localparam logic [2:0] SZ_8  = 3'd3;
  localparam logic [2:0] SZ_32 = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARB, ST_ADDR, ST_DATA, ST_DONE
  } bbmState_t;

  typedef struct packed {
    logic load;
    logic beatInc;
    logic setErr;
  } bbmStrobe_t;
endpackage

// File: rtl/bbm_datapath.sv
module bbm_datapath
  import bbm_pkg::*;
#(
  parameter int ADDR_W = 36,
  parameter int BEATS  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  bbmStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqSize,
  input  logic              reqWrite,
  output logic              reqBad,
  output logic              isWrite,
  output logic              lastBeat,
  output logic              errFlag,
  output logic [BUS_W-1:0]  hdr
);
  localparam int BEAT_W  = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int ALIGN_W = $clog2(BEATS * 8);

  logic [ADDR_W-1:0] addrQ;
  logic [2:0]        sizeQ;
  logic              writeQ;
  logic [BEAT_W-1:0] beatQ;
  logic              errQ;

  always_comb begin
    reqBad = (reqSize > SZ_32) ||
             ((reqSize == SZ_32) && (reqAddr[ALIGN_W-1:0] != '0));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      sizeQ  <= '0;
      writeQ <= 1'b0;
      beatQ  <= '0;
      errQ   <= 1'b0;
    end else begin
      if (strobe.load) begin
        addrQ  <= reqAddr;
        sizeQ  <= reqSize;
        writeQ <= reqWrite;
        beatQ  <= '0;
        errQ   <= 1'b0;
      end else if (strobe.beatInc) begin
        beatQ <= beatQ + 1'b1;
      end
      if (strobe.setErr) errQ <= 1'b1;
    end
  end

  assign lastBeat = (sizeQ == SZ_32) ? (beatQ == BEAT_W'(BEATS - 1)) : 1'b1;
  assign isWrite  = writeQ;
  assign errFlag  = errQ;

  always_comb begin
    hdr             = '0;
    hdr[ADDR_W-1:0] = addrQ;
    hdr[62:60]      = sizeQ;
    hdr[63]         = writeQ;
  end

  // R6
  beat_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.beatInc |-> !lastBeat);
  // R6
  single_no_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sizeQ != SZ_32) |-> (beatQ == '0));
endmodule

// File: rtl/bbm_ctrl.sv
module bbm_ctrl
  import bbm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       busGrant,
  input  logic       slvAck,
  input  logic       slvErr,
  input  logic       reqBad,
  input  logic       isWrite,
  input  logic       lastBeat,
  output bbmStrobe_t strobe,
  output logic       reqReady,
  output logic       busReq,
  output logic       addrPhase,
  output logic       adOe,
  output logic       rdValid,
  output logic       wrNext,
  output logic       rspValid
);
  bbmState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        if (reqBad) begin
          strobe.setErr = 1'b1;
          stateNext     = ST_DONE;
        end else begin
          strobe.load = 1'b1;
          stateNext   = ST_ARB;
        end
      end
      ST_ARB:  if (busGrant) stateNext = ST_ADDR;
      ST_ADDR: stateNext = ST_DATA;
      ST_DATA: begin
        if (slvErr) begin
          strobe.setErr = 1'b1;
          stateNext     = ST_DONE;
        end else if (slvAck) begin
          if (lastBeat) stateNext = ST_DONE;
          else          strobe.beatInc = 1'b1;
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  logic inData;
  assign inData    = (state == ST_DATA);
  assign reqReady  = (state == ST_IDLE);
  assign busReq    = (state == ST_ARB) || (state == ST_ADDR) || inData;
  assign addrPhase = (state == ST_ADDR);
  assign adOe      = addrPhase || (inData && isWrite);
  assign rdValid   = inData && slvAck && !slvErr && !isWrite;
  assign wrNext    = inData && slvAck && !slvErr && isWrite;
  assign rspValid  = (state == ST_DONE);

  // R4
  grant_before_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrPhase) |-> $past(busGrant));
  // R5
  addr_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrPhase |=> !addrPhase);
  // R9
  drive_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    adOe |-> busReq);
  // R10
  err_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inData && slvErr) |=> (rspValid && !busReq));
  // R11
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && reqReady));
endmodule

// File: rtl/burst_bus_master.sv
module burst_bus_master
  import bbm_pkg::*;
#(
  parameter int ADDR_W = 36,
  parameter int BEATS  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqSize,
  input  logic              reqWrite,
  input  logic [63:0]       reqWdata,
  output logic              reqReady,
  output logic              wrNext,
  output logic              rdValid,
  output logic [63:0]       rdData,
  output logic              rspValid,
  output logic              rspError,
  output logic              busReq,
  input  logic              busGrant,
  output logic              addrPhase,
  output logic              adOe,
  output logic [63:0]       adOut,
  input  logic [63:0]       adIn,
  input  logic              slvAck,
  input  logic              slvErr
);
  bbmStrobe_t       strobe;
  logic             reqBad, isWrite, lastBeat, errFlag;
  logic [BUS_W-1:0] hdr;

  bbm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .busGrant(busGrant),
    .slvAck(slvAck), .slvErr(slvErr), .reqBad(reqBad), .isWrite(isWrite),
    .lastBeat(lastBeat), .strobe(strobe), .reqReady(reqReady),
    .busReq(busReq), .addrPhase(addrPhase), .adOe(adOe),
    .rdValid(rdValid), .wrNext(wrNext), .rspValid(rspValid)
  );

  bbm_datapath #(.ADDR_W(ADDR_W), .BEATS(BEATS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWrite(reqWrite), .reqBad(reqBad),
    .isWrite(isWrite), .lastBeat(lastBeat), .errFlag(errFlag), .hdr(hdr)
  );

  assign adOut    = addrPhase ? hdr : reqWdata;
  assign rdData   = adIn;
  assign rspError = rspValid && errFlag;
endmodule

// File: tb/burst_bus_master_tb.sv
module burst_bus_master_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [35:0] reqAddr = '0;
  logic [2:0]  reqSize = '0;
  logic        reqWrite = 1'b0;
  logic [63:0] reqWdata = '0;
  logic        reqReady, wrNext, rdValid, rspValid, rspError;
  logic [63:0] rdData, adOut;
  logic        busReq, addrPhase, adOe;
  logic        busGrant = 1'b0;
  logic [63:0] adIn = '0;
  logic        slvAck = 1'b0, slvErr = 1'b0;

  int nTests = 0;
  int nFail  = 0;

  always #10 clk = ~clk;

  burst_bus_master u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .reqReady(reqReady), .wrNext(wrNext), .rdValid(rdValid), .rdData(rdData),
    .rspValid(rspValid), .rspError(rspError), .busReq(busReq),
    .busGrant(busGrant), .addrPhase(addrPhase), .adOe(adOe), .adOut(adOut),
    .adIn(adIn), .slvAck(slvAck), .slvErr(slvErr)
  );

  typedef struct packed {
    logic [35:0] addr;
    logic [2:0]  size;
    logic        wr;
    logic [3:0]  gntDly;
    logic [3:0]  waitN;
    logic [3:0]  errBeat;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{36'h0_0000_1000, 3'd0, 1'b0, 4'd0, 4'd0, 4'hF},
    '{36'h0_0000_2004, 3'd2, 1'b1, 4'd2, 4'd1, 4'hF},
    '{36'h1_2345_6788, 3'd3, 1'b0, 4'd1, 4'd3, 4'hF},
    '{36'h0_0000_3000, 3'd4, 1'b0, 4'd0, 4'd0, 4'hF},
    '{36'h0_ABCD_0020, 3'd4, 1'b1, 4'd3, 4'd2, 4'hF},
    '{36'h0_0000_4008, 3'd4, 1'b0, 4'd0, 4'd0, 4'hF},
    '{36'h0_0000_5000, 3'd7, 1'b0, 4'd0, 4'd0, 4'hF},
    '{36'h0_0000_6040, 3'd4, 1'b0, 4'd1, 4'd1, 4'd2},
    '{36'h0_0000_7001, 3'd1, 1'b1, 4'd0, 4'd0, 4'd0},
    '{36'h0_0000_8000, 3'd5, 1'b1, 4'd0, 4'd0, 4'hF}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rpat(logic [35:0] a, int b);
    return 64'hC0DE_0000_0000_0000 | (64'(a) << 4) | 64'(b);
  endfunction

  function automatic logic [63:0] wpat(logic [35:0] a, int b);
    return 64'hFACE_0000_0000_0000 | (64'(a) << 4) | 64'(b);
  endfunction

  task automatic runTxn(input vec_t v);
    bit rej = (v.size > 3'd4) || ((v.size == 3'd4) && (v.addr[4:0] != 5'd0));
    int beatsExp = (v.size == 3'd4) ? 4 : 1;
    bit expErr = rej || (int'(v.errBeat) < beatsExp);
    int beatsWant = rej ? 0 : ((int'(v.errBeat) < beatsExp) ? int'(v.errBeat) : beatsExp);
    int beats = 0, waitLeft = int'(v.waitN), cyc = 0, gntCnt = 0, gntAt = -10;
    int addrCnt = 0, rdIdx = 0;
    bit inData = 0, stopped = 0, sawReq = 0, done = 0;
    logic [63:0] hdrExp;
    hdrExp = 64'(v.addr) | (64'(v.size) << 60) | (64'(v.wr) << 63);
    @(negedge clk);
    chk(reqReady, "R11 ready before request", 64'(reqReady), 64'd1);
    reqAddr = v.addr; reqSize = v.size; reqWrite = v.wr;
    reqWdata = wpat(v.addr, 0); reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (!done && cyc < 200) begin
      if (busReq) sawReq = 1;
      if (rspValid) begin
        done = 1;
        busGrant = 1'b0;
        chk(rspError == expErr, rej ? "R2/R3 reject error" : "R10 error flag",
            64'(rspError), 64'(expErr));
        chk(beats == beatsWant, "R6 beat count", 64'(beats), 64'(beatsWant));
        chk(!busReq, "R11 request released", 64'(busReq), 64'd0);
        chk(addrCnt == (rej ? 0 : 1), "R5 address phase count", 64'(addrCnt),
            64'(rej ? 0 : 1));
        if (rej) chk(!sawReq, "R2 R3 no bus use on reject", 64'(sawReq), 64'd0);
      end else begin
        if (addrPhase) begin
          addrCnt++;
          chk(gntAt == cyc - 1, "R4 address right after grant", 64'(gntAt), 64'(cyc - 1));
          chk(adOe && adOut == hdrExp, "R5 header", adOut, hdrExp);
        end
        if (busReq) begin
          if (gntCnt >= int'(v.gntDly)) begin
            if (!busGrant) gntAt = cyc;
            busGrant = 1'b1;
          end else gntCnt++;
        end else busGrant = 1'b0;
        slvAck = 1'b0; slvErr = 1'b0;
        if (inData && !stopped && beats < beatsExp) begin
          adIn = rpat(v.addr, beats);
          if (waitLeft > 0) waitLeft--;
          else if (int'(v.errBeat) == beats) slvErr = 1'b1;
          else slvAck = 1'b1;
        end
        #1;
        if (inData && !stopped && beats < beatsExp && v.wr)
          chk(adOe && adOut == wpat(v.addr, beats), "R9 write data driven", adOut,
              wpat(v.addr, beats));
        if (slvAck) begin
          if (v.wr) chk(wrNext && !rdValid, "R9 wrNext on ack", 64'(wrNext), 64'd1);
          else chk(rdValid && rdData == rpat(v.addr, rdIdx), "R8 read beat", rdData,
                   rpat(v.addr, rdIdx));
          if (!v.wr) rdIdx++;
          beats++;
          waitLeft = int'(v.waitN);
          reqWdata = wpat(v.addr, beats);
        end else begin
          chk(!rdValid && !wrNext, "R7 no beat without ack",
              64'({rdValid, wrNext}), 64'd0);
        end
        if (slvErr) stopped = 1;
        if (addrPhase) inData = 1;
      end
      cyc++;
      @(negedge clk);
      slvAck = 1'b0; slvErr = 1'b0;
    end
    if (!done) chk(1'b0, "R11 completion timeout", 64'(cyc), 64'd0);
    chk(!rspValid && reqReady, "R11 pulse then ready", 64'({rspValid, reqReady}), 64'b01);
  endtask

  initial begin
    #(20 * 150000);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(reqReady && !busReq && !adOe && !addrPhase && !rspValid, "R1 reset state",
        64'({reqReady, busReq, adOe, addrPhase, rspValid}), 64'b10000);
    rstN = 1'b1;
    for (int i = 0; i < NV; i++) runTxn(VECS[i]);
    // R1 reset during arbitration wait: bus released at once
    @(negedge clk);
    reqAddr = 36'h0_0000_9000; reqSize = 3'd4; reqWrite = 1'b0; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(busReq, "R4 request raised", 64'(busReq), 64'd1);
    rstN = 1'b0;
    @(negedge clk);
    chk(reqReady && !busReq && !adOe && !rspValid, "R1 reset mid transfer",
        64'({reqReady, busReq, adOe, rspValid}), 64'b1000);
    rstN = 1'b1;
    // R4 no address phase while grant withheld
    @(negedge clk);
    reqAddr = 36'h0_0000_A000; reqSize = 3'd0; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(busReq && !addrPhase, "R4 wait for grant", 64'({busReq, addrPhase}), 64'b10);
    end
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule